// File: doc/BRIEF.md
# Single-Transfer Bus Master with Byte-Lane Steering

This block turns simple read and write commands from a local command port into classic, non-burst bus cycles on a shared-clock 32-bit bus. Only one transfer is in flight at a time. A command is taken through a ready/valid handshake. The master drives `cyc` and `stb` together until the slave answers with an acknowledge, an error or a retry. The outcome then comes back as a one-cycle response pulse on the command side.

Byte and halfword accesses are steered onto the correct lanes inside the block. The byte select is a one-hot mask shifted left by the low address bits. Write data is replicated across every lane that could be selected. Read data is taken from the addressed lane and zero-extended. Word accesses select all four lanes and pass the data through unchanged. The block runs from the same clock and reset as the bus and creates neither.

Top module: `wbm_byte_master`

## Requirements
- R1: While `rst_n` is low and after it is released, `wb_cyc_o` and `wb_stb_o` are low, `rsp_valid` is low and `cmd_ready` is high, until a command is presented.
- R2: `wb_cti_o` is 3'b000 in every cycle.
- R3: In the cycle after a command is accepted, `wb_cyc_o` and `wb_stb_o` rise together. They stay high with address, select, write enable and data unchanged until `wb_ack_i`, `wb_err_i` or `wb_rty_i` is sampled high.
- R4: `wb_we_o` equals the accepted `cmd_write`. `wb_adr_o` is `cmd_addr` with bits [1:0] cleared.
- R5: For a byte write (`cmd_size` = 2'b00), `wb_sel_o` = 4'b0001 << `cmd_addr[1:0]` and `wb_dat_o` holds `cmd_wdata[7:0]` in all four byte lanes.
- R6: For a byte read, `cmd_addr[1:0]` = 00, 01, 10, 11 returns `wb_dat_i` bits [7:0], [15:8], [23:16], [31:24] respectively, zero-extended to 32 bits.
- R7: For a halfword access (`cmd_size` = 2'b01), `wb_sel_o` is 4'b0011 when `cmd_addr[1]` = 0 and 4'b1100 when it is 1, with `cmd_addr[0]` ignored. The write data is `cmd_wdata[15:0]` in both halves. Read data is the selected half, zero-extended.
- R8: For a word access (`cmd_size` = 2'b10 or 2'b11), `wb_sel_o` = 4'b1111. Write data and read data pass through unchanged.
- R9: In the cycle after `wb_ack_i` is sampled during a transfer, `wb_cyc_o`/`wb_stb_o` are low and `rsp_valid` is high for exactly one cycle with `rsp_error` = 0. `rsp_rdata` holds the read result, or zero for a write.
- R10: A transfer ended by `wb_err_i` or `wb_rty_i` ends the same way but with `rsp_error` = 1 and `rsp_rdata` = 0. No new cycle starts without a new command.
- R11: `cmd_ready` is high only while no transfer is in progress. A command presented during a transfer is not taken and does not change the bus signals.
- R12: `wb_ack_i`, `wb_err_i` or `wb_rty_i` asserted while idle produce no response and no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the bus |
| rst_n | input | 1 | Synchronous active-low reset shared with the bus |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Master idle, command will be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| cmd_addr | input | 32 | Byte address |
| cmd_wdata | input | 32 | Write data, right-aligned for narrow accesses |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Transfer ended with error or retry |
| rsp_rdata | output | 32 | Read result, zero-extended |
| wb_adr_o | output | 32 | Word-aligned bus address |
| wb_dat_o | output | 32 | Bus write data |
| wb_dat_i | input | 32 | Bus read data |
| wb_sel_o | output | 4 | Byte-lane select |
| wb_we_o | output | 1 | Write enable |
| wb_stb_o | output | 1 | Strobe |
| wb_cyc_o | output | 1 | Cycle valid |
| wb_cti_o | output | 3 | Cycle type tag, always classic |
| wb_ack_i | input | 1 | Normal termination |
| wb_err_i | input | 1 | Error termination |
| wb_rty_i | input | 1 | Retry termination |

## Verification
The bench covers every byte lane in both directions. A reversed or priority-style lane mapping would put the select bit in the wrong place and return the mirrored byte. It drives halfword accesses with an odd address, where a design that honoured bit 0 would shift the select off its pair. It ends transfers with error and retry, where a design that retried on its own would raise the cycle again, and one that kept the read data would return nonzero data. It also sends a command during a busy cycle and strobes a termination while idle, which catch a master that accepts early or reacts to stray acknowledges.

// File: rtl/wbm_pkg.sv
// Shared types for the byte-lane bus master.
// Assumes a byte-addressed bus whose data width is a power-of-two number of bytes.
package wbm_pkg;

    // Access size carried on the command port.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

    // Transfer sequencer state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } cyc_state_e;

endpackage

// File: rtl/wbm_lane_pack.sv
// Builds the byte-select mask and the lane-replicated write data for one access.
// Assumes DATA_W is a multiple of 16 and lane = low address bits.
module wbm_lane_pack
    import wbm_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int LB    = $clog2(LANES)
) (
    input  acc_size_e         size,
    input  logic [LB-1:0]     lane,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  sel,
    output logic [DATA_W-1:0] dat
);

    logic [DATA_W-1:0] byte_rep;
    logic [DATA_W-1:0] half_rep;
    logic [LB-1:0]     half_lane;

    // Replicate the low byte and the low halfword over every lane.
    for (genvar g = 0; g < LANES; g++) begin : g_rep
        assign byte_rep[g*8 +: 8] = wdata[7:0];
        assign half_rep[g*8 +: 8] = wdata[(g % 2)*8 +: 8];
    end

    // Halfword accesses start on an even lane; bit 0 of the address is dropped.
    assign half_lane = {lane[LB-1:1], 1'b0};

    // Select mask: one-hot shift for bytes, pair shift for halfwords, all lanes otherwise.
    always_comb begin
        unique case (size)
            SZ_BYTE: sel = LANES'(1) << lane;
            SZ_HALF: sel = LANES'(3) << half_lane;
            default: sel = '1;
        endcase
    end

    // Write data that matches the chosen mask.
    always_comb begin
        unique case (size)
            SZ_BYTE: dat = byte_rep;
            SZ_HALF: dat = half_rep;
            default: dat = wdata;
        endcase
    end

endmodule

// File: rtl/wbm_lane_unpack.sv
// Extracts the addressed byte or halfword from bus read data and zero-extends it.
// Assumes lane = low address bits captured when the command was accepted.
module wbm_lane_unpack
    import wbm_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int LB    = $clog2(LANES)
) (
    input  acc_size_e         size,
    input  logic [LB-1:0]     lane,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] value
);

    logic [DATA_W-1:0] byte_sh;
    logic [DATA_W-1:0] half_sh;

    // Move the addressed lane down to bit 0.
    assign byte_sh = rdata >> {lane, 3'b000};
    assign half_sh = rdata >> {lane[LB-1:1], 4'b0000};

    // Keep only the accessed width; upper bits become zero.
    always_comb begin
        unique case (size)
            SZ_BYTE: value = DATA_W'(byte_sh[7:0]);
            SZ_HALF: value = DATA_W'(half_sh[15:0]);
            default: value = rdata;
        endcase
    end

endmodule

// File: rtl/wbm_cycle_fsm.sv
// Two-state sequencer: idle until a command is handed over, then busy until the
// slave terminates the cycle. Assumes terminations are only meaningful while busy.
module wbm_cycle_fsm
    import wbm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic term_any,
    output logic idle,
    output logic busy,
    output logic launch,
    output logic finish
);

    cyc_state_e state_q;
    cyc_state_e state_d;

    assign idle   = (state_q == ST_IDLE);
    assign busy   = (state_q == ST_BUS);
    assign launch = idle & cmd_valid;
    assign finish = busy & term_any;

    // Next-state choice.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) state_d = ST_BUS;
            ST_BUS:  if (term_any)  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/wbm_byte_master.sv
// Single-outstanding classic bus master with byte/halfword lane steering.
// Assumes the bus shares clk and rst_n; only non-burst cycles are issued.
module wbm_byte_master
    import wbm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int LB    = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [1:0]        cmd_size,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic              rsp_error,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] wb_adr_o,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic [DATA_W-1:0] wb_dat_i,
    output logic [LANES-1:0]  wb_sel_o,
    output logic              wb_we_o,
    output logic              wb_stb_o,
    output logic              wb_cyc_o,
    output logic [2:0]        wb_cti_o,
    input  logic              wb_ack_i,
    input  logic              wb_err_i,
    input  logic              wb_rty_i
);

    logic              idle, busy, launch, finish, term_any, term_bad;
    acc_size_e         cmd_sz;
    logic [LANES-1:0]  pack_sel;
    logic [DATA_W-1:0] pack_dat;
    logic [DATA_W-1:0] unpack_val;

    logic [ADDR_W-1:0] adr_q;
    logic [DATA_W-1:0] dat_q;
    logic [LANES-1:0]  sel_q;
    logic              we_q;
    acc_size_e         size_q;
    logic [LB-1:0]     lane_q;

    logic              rsp_valid_q, rsp_error_q;
    logic [DATA_W-1:0] rsp_rdata_q;

    assign cmd_sz   = acc_size_e'(cmd_size);
    assign term_any = wb_ack_i | wb_err_i | wb_rty_i;
    assign term_bad = wb_err_i | wb_rty_i;

    wbm_cycle_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .term_any (term_any),
        .idle     (idle),
        .busy     (busy),
        .launch   (launch),
        .finish   (finish)
    );

    wbm_lane_pack #(.DATA_W(DATA_W)) u_pack (
        .size (cmd_sz),
        .lane (cmd_addr[LB-1:0]),
        .wdata(cmd_wdata),
        .sel  (pack_sel),
        .dat  (pack_dat)
    );

    wbm_lane_unpack #(.DATA_W(DATA_W)) u_unpack (
        .size (size_q),
        .lane (lane_q),
        .rdata(wb_dat_i),
        .value(unpack_val)
    );

    // Capture the bus-side view of a command when it is handed over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adr_q  <= '0;
            dat_q  <= '0;
            sel_q  <= '0;
            we_q   <= 1'b0;
            size_q <= SZ_WORD;
            lane_q <= '0;
        end else if (launch) begin
            adr_q  <= {cmd_addr[ADDR_W-1:LB], LB'(0)};
            dat_q  <= pack_dat;
            sel_q  <= pack_sel;
            we_q   <= cmd_write;
            size_q <= cmd_sz;
            lane_q <= cmd_addr[LB-1:0];
        end
    end

    // Produce a one-cycle response when the slave ends the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_error_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= finish;
            if (finish) begin
                rsp_error_q <= term_bad;
                rsp_rdata_q <= (!term_bad && !we_q) ? unpack_val : '0;
            end
        end
    end

    assign cmd_ready = idle;
    assign rsp_valid = rsp_valid_q;
    assign rsp_error = rsp_error_q;
    assign rsp_rdata = rsp_rdata_q;

    assign wb_adr_o = adr_q;
    assign wb_dat_o = dat_q;
    assign wb_sel_o = sel_q;
    assign wb_we_o  = we_q;
    assign wb_cyc_o = busy;
    assign wb_stb_o = busy;
    assign wb_cti_o = 3'b000;

endmodule

// File: rtl/wbm_byte_master_chk.sv
// Protocol checker for the byte-lane bus master, attached by bind.
// Assumes the synchronous active-low reset of the master.
module wbm_byte_master_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_write,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] wb_adr_o,
    input logic [DATA_W-1:0] wb_dat_o,
    input logic [LANES-1:0]  wb_sel_o,
    input logic              wb_we_o,
    input logic              wb_stb_o,
    input logic              wb_cyc_o,
    input logic [2:0]        wb_cti_o,
    input logic              wb_ack_i,
    input logic              wb_err_i,
    input logic              wb_rty_i
);

    logic term;
    assign term = wb_ack_i | wb_err_i | wb_rty_i;

    AST_CTI_CLASSIC: assert property (@(posedge clk) disable iff (!rst_n) wb_cti_o == 3'b000); // R2
    AST_STB_WITH_CYC: assert property (@(posedge clk) disable iff (!rst_n) wb_stb_o == wb_cyc_o); // R3
    AST_HOLD_UNTIL_TERM: assert property (@(posedge clk) disable iff (!rst_n) (wb_cyc_o && !term) |=> (wb_cyc_o && $stable(wb_adr_o) && $stable(wb_sel_o) && $stable(wb_we_o) && $stable(wb_dat_o))); // R3
    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && cmd_ready) |=> (wb_cyc_o && wb_we_o == $past(cmd_write))); // R4
    AST_SEL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) wb_cyc_o |-> (wb_sel_o != '0)); // R5
    AST_TERM_ENDS: assert property (@(posedge clk) disable iff (!rst_n) (wb_cyc_o && term) |=> (!wb_cyc_o && rsp_valid)); // R9
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R9
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) cmd_ready |-> !wb_cyc_o); // R11
    AST_IDLE_TERM_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!wb_cyc_o && term) |=> !rsp_valid); // R12

endmodule

bind wbm_byte_master wbm_byte_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_write(cmd_write),
    .rsp_valid(rsp_valid),
    .wb_adr_o (wb_adr_o),
    .wb_dat_o (wb_dat_o),
    .wb_sel_o (wb_sel_o),
    .wb_we_o  (wb_we_o),
    .wb_stb_o (wb_stb_o),
    .wb_cyc_o (wb_cyc_o),
    .wb_cti_o (wb_cti_o),
    .wb_ack_i (wb_ack_i),
    .wb_err_i (wb_err_i),
    .wb_rty_i (wb_rty_i)
);

// File: tb/wbm_byte_master_test.sv
`timescale 1ns/1ps
module wbm_byte_master_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_write = 1'b0;
    logic [1:0]  cmd_size = 2'b00;
    logic [31:0] cmd_addr = '0;
    logic [31:0] cmd_wdata = '0;
    logic        rsp_valid, rsp_error;
    logic [31:0] rsp_rdata;
    logic [31:0] wb_adr_o, wb_dat_o;
    logic [31:0] wb_dat_i = '0;
    logic [3:0]  wb_sel_o;
    logic        wb_we_o, wb_stb_o, wb_cyc_o;
    logic [2:0]  wb_cti_o;
    logic        wb_ack_i = 1'b0, wb_err_i = 1'b0, wb_rty_i = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    wbm_byte_master uut (.*);

    function automatic logic [3:0] exp_sel(input logic [1:0] sz, input logic [31:0] a);
        case (sz)
            2'b00:   return 4'b0001 << a[1:0];
            2'b01:   return a[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] exp_dat(input logic [1:0] sz, input logic [31:0] w);
        case (sz)
            2'b00:   return {4{w[7:0]}};
            2'b01:   return {2{w[15:0]}};
            default: return w;
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
        case (sz)
            2'b00: case (a[1:0])
                2'b00:   return {24'h0, d[7:0]};
                2'b01:   return {24'h0, d[15:8]};
                2'b10:   return {24'h0, d[23:16]};
                default: return {24'h0, d[31:24]};
            endcase
            2'b01:   return a[1] ? {16'h0, d[31:16]} : {16'h0, d[15:0]};
            default: return d;
        endcase
    endfunction

    function automatic string lane_req(input bit wr, input logic [1:0] sz);
        if (sz == 2'b00) return wr ? "R5" : "R6";
        if (sz == 2'b01) return "R7";
        return "R8";
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One transfer; called at one time unit after a rising edge.
    // kind: 0 ack, 1 err, 2 rty.
    task automatic run_txn(input bit wr, input logic [1:0] sz, input logic [31:0] a,
                           input logic [31:0] wd, input logic [31:0] bus_rd,
                           input int kind, input int delay, input bit poke);
        string lr;
        lr = lane_req(wr, sz);
        cmd_valid = 1'b1; cmd_write = wr; cmd_size = sz; cmd_addr = a; cmd_wdata = wd;
        chk("R11", "ready when idle", {31'h0, cmd_ready}, 32'd1);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        chk("R3", "cyc raised", {31'h0, wb_cyc_o}, 32'd1);
        chk("R3", "stb raised", {31'h0, wb_stb_o}, 32'd1);
        chk("R4", "we", {31'h0, wb_we_o}, {31'h0, wr});
        chk("R4", "adr", wb_adr_o, {a[31:2], 2'b00});
        chk(lr, "sel", {28'h0, wb_sel_o}, {28'h0, exp_sel(sz, a)});
        if (wr) chk(lr, "write data", wb_dat_o, exp_dat(sz, wd));
        chk("R2", "cti", {29'h0, wb_cti_o}, 32'd0);
        for (int i = 0; i < delay; i++) begin
            if (poke && i == 0) begin
                cmd_valid = 1'b1; cmd_addr = ~a; cmd_write = ~wr; cmd_size = 2'b10;
                chk("R11", "ready while busy", {31'h0, cmd_ready}, 32'd0);
            end
            @(posedge clk); #1;
            cmd_valid = 1'b0;
            chk("R3", "cyc held", {31'h0, wb_cyc_o}, 32'd1);
            chk("R11", "adr unchanged", wb_adr_o, {a[31:2], 2'b00});
            chk("R3", "sel held", {28'h0, wb_sel_o}, {28'h0, exp_sel(sz, a)});
            chk("R11", "we unchanged", {31'h0, wb_we_o}, {31'h0, wr});
        end
        wb_dat_i = bus_rd;
        wb_ack_i = (kind == 0);
        wb_err_i = (kind == 1);
        wb_rty_i = (kind == 2);
        @(posedge clk); #1;
        wb_ack_i = 1'b0; wb_err_i = 1'b0; wb_rty_i = 1'b0;
        chk("R9", "cyc dropped", {31'h0, wb_cyc_o}, 32'd0);
        chk("R9", "rsp_valid", {31'h0, rsp_valid}, 32'd1);
        if (kind == 0) begin
            chk("R9", "rsp_error", {31'h0, rsp_error}, 32'd0);
            chk(wr ? "R9" : lr, "rsp_rdata", rsp_rdata, wr ? 32'h0 : exp_rd(sz, a, bus_rd));
        end else begin
            chk("R10", "rsp_error", {31'h0, rsp_error}, 32'd1);
            chk("R10", "rsp_rdata", rsp_rdata, 32'h0);
        end
        wb_dat_i = 32'h0;
        @(posedge clk); #1;
        chk("R9", "rsp pulse ends", {31'h0, rsp_valid}, 32'd0);
        chk("R10", "no retry cycle", {31'h0, wb_cyc_o}, 32'd0);
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "cyc in reset", {31'h0, wb_cyc_o}, 32'd0);
        chk("R1", "rsp_valid in reset", {31'h0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "ready after reset", {31'h0, cmd_ready}, 32'd1);
        chk("R1", "stb after reset", {31'h0, wb_stb_o}, 32'd0);
        chk("R2", "cti after reset", {29'h0, wb_cti_o}, 32'd0);

        // Every byte lane, both directions.
        for (int l = 0; l < 4; l++) begin
            run_txn(1'b1, 2'b00, 32'h1000_0000 + l, 32'hCAFE_00A5 + l, 32'h0, 0, l, 1'b0);
            run_txn(1'b0, 2'b00, 32'h2000_0040 + l, 32'h0, 32'h8844_C211, 0, 3 - l, 1'b0);
        end
        // Halfwords, including odd addresses.
        run_txn(1'b1, 2'b01, 32'h0000_0101, 32'h1234_BEEF, 32'h0, 0, 1, 1'b0);
        run_txn(1'b1, 2'b01, 32'h0000_0103, 32'h1234_F00D, 32'h0, 0, 0, 1'b0);
        run_txn(1'b0, 2'b01, 32'h0000_0201, 32'h0, 32'h9ABC_DEF0, 0, 2, 1'b0);
        run_txn(1'b0, 2'b01, 32'h0000_0202, 32'h0, 32'h9ABC_DEF0, 0, 0, 1'b0);
        // Words, both size codes.
        run_txn(1'b1, 2'b10, 32'h0000_0303, 32'hDEAD_BEEF, 32'h0, 0, 0, 1'b0);
        run_txn(1'b0, 2'b11, 32'h0000_0400, 32'h0, 32'hF1E2_D3C4, 0, 1, 1'b0);
        // Error and retry terminations.
        run_txn(1'b0, 2'b00, 32'h0000_0502, 32'h0, 32'hFFFF_FFFF, 1, 1, 1'b0);
        run_txn(1'b1, 2'b10, 32'h0000_0600, 32'h5555_AAAA, 32'h0, 2, 0, 1'b0);
        run_txn(1'b0, 2'b10, 32'h0000_0604, 32'h0, 32'h7777_7777, 2, 2, 1'b0);
        // Command offered while busy.
        run_txn(1'b1, 2'b00, 32'h0000_0701, 32'h0000_003C, 32'h0, 0, 3, 1'b1);

        // Terminations while idle are ignored.
        wb_ack_i = 1'b1; wb_err_i = 1'b1; wb_rty_i = 1'b1; wb_dat_i = 32'h1111_2222;
        @(posedge clk); #1;
        wb_ack_i = 1'b0; wb_err_i = 1'b0; wb_rty_i = 1'b0; wb_dat_i = 32'h0;
        chk("R12", "no response when idle", {31'h0, rsp_valid}, 32'd0);
        chk("R12", "no cycle when idle", {31'h0, wb_cyc_o}, 32'd0);
        @(posedge clk); #1;
        chk("R12", "still idle", {31'h0, cmd_ready}, 32'd1);

        // Random mix.
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            int k;
            r = $urandom;
            k = (r[7:4] == 4'hF) ? 1 : ((r[7:4] == 4'hE) ? 2 : 0);
            run_txn(r[0], r[2:1], $urandom, $urandom, $urandom, k, int'(r[10:8] % 4), r[11] & (r[10:8] % 4 != 0));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule